// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects five interrupt request flags (two external lines, two timer overflows and one serial event) and decides which of them a small CPU core should service next. Each source is gated by its own enable bit and by a global enable, and each is assigned by software to either a high or a low priority level. Inside a level, ties are broken by a fixed polling order. The winner's vector address and a one-cycle take strobe are presented on the cycle the core signals an instruction boundary.

The controller remembers which priority levels are in service. It lets a high-level request interrupt a low-level routine and blocks every other form of nesting. A return strobe from the core releases the most recently entered level. When the core vectors to a timer source, or to an external source configured for edge detection, the block clears that pending flag and pulses a matching clear output. Serial and level-mode external flags are left for software to clear. Software reaches four byte-wide registers over a plain write-enable bus. Writing the pending register can raise an interrupt or cancel one.

Top module: `irq2_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the enable, priority, pending and mode registers and both in-service levels are 0, `take` is 0, `vec_addr` is 0000h and `flag_clr` is 0.
- R2: A source is requested only when its pending bit, its own enable bit and the global enable (enable register bit 7) are all 1. Enable bits 6 and 5 read as 0.
- R3: Priority register bit n (bits 4..0, same positions as the enables) set to 1 puts source n in the high level. Any eligible high-level request wins over every low-level request.
- R4: Within one level the lowest bit index wins. The bit order is external 0 (bit 0), timer 0 (bit 1), external 1 (bit 2), timer 1 (bit 3), serial (bit 4). The vectors are 0003h, 000Bh, 0013h, 001Bh and 0023h respectively.
- R5: `take` is 1 only in a cycle where `instr_end` is 1 and a request is eligible. In that same cycle `vec_addr` carries the vector. Otherwise `vec_addr` is 0000h.
- R6: When nothing is in service, any eligible request is taken. While only the low level is in service, only high-level requests are taken. While the high level is in service, nothing is taken. A blocked request stays pending.
- R7: A take marks its level as in service. The low level reads at register 3 bit 4 and the high level at bit 5.
- R8: On a take of timer 0, timer 1, or an external source whose mode bit is 1 (register 3 bit 0 for external 0, bit 1 for external 1), `flag_clr` pulses that source's bit in the same cycle and the pending bit is cleared. Serial and level-mode external flags are never cleared.
- R9: `reti` clears the high in-service level if it is set, and otherwise clears the low level. In a cycle with both `reti` and a take, the release is applied first.
- R10: A write to the pending register replaces the pending bits. A set bit is taken like a hardware event, and a cleared bit cancels that request. The `irq_set` pulses set pending bits and win over a same-cycle write or automatic clear.
- R11: Register addresses are 0 enable, 1 priority, 2 pending, 3 mode/status. `reg_rdata` shows the addressed register combinationally, and unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Addressed register contents |
| irq_set | input | 5 | Hardware event pulses, one per source |
| instr_end | input | 1 | Current instruction completes this cycle |
| reti | input | 1 | Return-from-interrupt strobe |
| take | output | 1 | Interrupt accepted this cycle |
| vec_addr | output | 16 | Vector of the accepted source |
| flag_clr | output | 5 | Clear pulse for the automatically cleared flag |

## Verification
The bench builds the controller with its default parameters: a 16-bit vector, a base of 3 and a stride of 8. These defaults reach the five specified vector addresses exactly. Directed phases cover masking, priority reversal, the polling order, preemption of a low routine, blocking under a high routine, and edge versus level clearing. A long random phase then mixes register writes, event pulses, boundaries and returns, which covers same-cycle collisions of writes, sets, clears and releases.

// File: rtl/irq2_pkg.sv
// Package: shared constants for the two-level interrupt controller.
// Assumes five sources in fixed polling order; indices double as bit positions.
package irq2_pkg;
    localparam int SRC_N    = 5;
    localparam int IDX_W    = 3;
    localparam int SRC_EXT0 = 0;
    localparam int SRC_TMR0 = 1;
    localparam int SRC_EXT1 = 2;
    localparam int SRC_TMR1 = 3;
    localparam int SRC_SER  = 4;
    localparam int GEN_BIT  = 7;

    typedef enum logic [1:0] {
        A_ENA = 2'd0,
        A_PRI = 2'd1,
        A_PND = 2'd2,
        A_CFG = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq2_regs.sv
// Module: software-visible registers and the pending flags.
// Assumes hardware sets (hw_set) win over a same-cycle write or automatic clear.
module irq2_regs
    import irq2_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic             wr_gen,
    input  logic [SRC_N-1:0] wr_src,
    input  logic [1:0]       wr_mode,
    input  logic [SRC_N-1:0] hw_set,
    input  logic [SRC_N-1:0] clr_mask,
    input  logic             busy_hi,
    input  logic             busy_lo,
    output logic             gen_en,
    output logic [SRC_N-1:0] src_en,
    output logic [SRC_N-1:0] prio,
    output logic [SRC_N-1:0] pend,
    output logic [1:0]       edge_mode,
    output logic [7:0]       rdata
);
    logic [SRC_N-1:0] pend_nx;

    // Configuration registers: enable, priority, mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_en    <= 1'b0;
            src_en    <= '0;
            prio      <= '0;
            edge_mode <= '0;
        end else if (we) begin
            case (addr)
                A_ENA: begin
                    gen_en <= wr_gen;
                    src_en <= wr_src;
                end
                A_PRI:   prio      <= wr_src;
                A_CFG:   edge_mode <= wr_mode;
                default: ;
            endcase
        end
    end

    // Next pending value: write, then automatic clear, then hardware set.
    always_comb begin
        pend_nx = pend;
        if (we && addr == A_PND) pend_nx = wr_src;
        pend_nx = (pend_nx & ~clr_mask) | hw_set;
    end

    // Pending flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_nx;
    end

    // Read multiplexer; unused bits read as zero.
    always_comb begin
        rdata = '0;
        case (addr)
            A_ENA: begin
                rdata[GEN_BIT]   = gen_en;
                rdata[SRC_N-1:0] = src_en;
            end
            A_PRI: rdata[SRC_N-1:0] = prio;
            A_PND: rdata[SRC_N-1:0] = pend;
            A_CFG: rdata = {2'b00, busy_hi, busy_lo, 2'b00, edge_mode};
            default: ;
        endcase
    end

    // R8: serial flag survives unless software writes the pending register.
    p_serial_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend[SRC_SER] && !(we && addr == A_PND) |=> pend[SRC_SER]);

    // R8: an automatic clear without a competing set or write drops the flag.
    p_clr_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_mask[SRC_TMR0] && !hw_set[SRC_TMR0] && !(we && addr == A_PND)
        |=> !pend[SRC_TMR0]);
endmodule

// File: rtl/irq2_arbiter.sv
// Module: masks the pending flags, applies level blocking and picks a winner.
// Assumes busy_hi implies the most recent routine is high level.
module irq2_arbiter
    import irq2_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  pend,
    input  logic [SRC_N-1:0]  src_en,
    input  logic              gen_en,
    input  logic [SRC_N-1:0]  prio,
    input  logic              busy_hi,
    input  logic              busy_lo,
    output logic              grant_valid,
    output logic [IDX_W-1:0]  grant_idx,
    output logic              grant_hi
);
    logic [SRC_N-1:0] active, hi_req, lo_req, elig;

    // Level filtering: which requests may be taken now.
    always_comb begin
        active = gen_en ? (pend & src_en) : '0;
        hi_req = active & prio;
        lo_req = active & ~prio;
        if (busy_hi)      elig = '0;
        else if (busy_lo) elig = hi_req;
        else              elig = (|hi_req) ? hi_req : lo_req;
    end

    // Fixed polling order: lowest index wins.
    always_comb begin
        grant_valid = 1'b0;
        grant_idx   = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                grant_valid = 1'b1;
                grant_idx   = IDX_W'(i);
            end
        end
        grant_hi = |(elig & prio);
    end

    // R6: nothing is granted while the high level is in service.
    p_hi_blocks_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_hi |-> !grant_valid);

    // R6: under a low routine only a high-level source may be granted.
    p_lo_only_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_lo && grant_valid |-> prio[grant_idx]);
endmodule

// File: rtl/irq2_levels.sv
// Module: tracks the in-service state of the two priority levels.
// Assumes the high level, when set, is always the most recently entered one.
module irq2_levels (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic take_hi,
    input  logic reti,
    output logic busy_hi,
    output logic busy_lo
);
    logic hi_nx, lo_nx;

    // Release first, then enter the accepted level.
    always_comb begin
        hi_nx = busy_hi;
        lo_nx = busy_lo;
        if (reti) begin
            if (busy_hi) hi_nx = 1'b0;
            else         lo_nx = 1'b0;
        end
        if (take) begin
            if (take_hi) hi_nx = 1'b1;
            else         lo_nx = 1'b1;
        end
    end

    // In-service state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_hi <= 1'b0;
            busy_lo <= 1'b0;
        end else begin
            busy_hi <= hi_nx;
            busy_lo <= lo_nx;
        end
    end

    // R7: a high-level take marks the high level busy next cycle.
    p_take_sets_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take && take_hi |=> busy_hi);

    // R9: a return during a high routine releases the high level.
    p_reti_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_hi && reti && !take |=> !busy_hi);
endmodule

// File: rtl/irq2_ctrl.sv
// Module: top of the two-level interrupt controller.
// Assumes the core samples take/vec_addr in the instr_end cycle and later issues reti.
module irq2_ctrl
    import irq2_pkg::*;
#(
    parameter int VEC_W    = 16,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [SRC_N-1:0] irq_set,
    input  logic             instr_end,
    input  logic             reti,
    output logic             take,
    output logic [VEC_W-1:0] vec_addr,
    output logic [SRC_N-1:0] flag_clr
);
    logic             gen_en, busy_hi, busy_lo;
    logic             grant_valid, grant_hi, clr_ok;
    logic [SRC_N-1:0] src_en, prio, pend;
    logic [1:0]       edge_mode;
    logic [IDX_W-1:0] grant_idx;
    logic             unused_wbits;

    assign unused_wbits = ^reg_wdata[6:5];

    irq2_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wr_gen    (reg_wdata[GEN_BIT]),
        .wr_src    (reg_wdata[SRC_N-1:0]),
        .wr_mode   (reg_wdata[1:0]),
        .hw_set    (irq_set),
        .clr_mask  (flag_clr),
        .busy_hi   (busy_hi),
        .busy_lo   (busy_lo),
        .gen_en    (gen_en),
        .src_en    (src_en),
        .prio      (prio),
        .pend      (pend),
        .edge_mode (edge_mode),
        .rdata     (reg_rdata)
    );

    irq2_arbiter u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend        (pend),
        .src_en      (src_en),
        .gen_en      (gen_en),
        .prio        (prio),
        .busy_hi     (busy_hi),
        .busy_lo     (busy_lo),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .grant_hi    (grant_hi)
    );

    irq2_levels u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .take_hi (grant_hi),
        .reti    (reti),
        .busy_hi (busy_hi),
        .busy_lo (busy_lo)
    );

    // Acceptance at an instruction boundary.
    assign take = instr_end & grant_valid;

    // Decide whether the accepted source is cleared by hardware.
    always_comb begin
        case (int'(grant_idx))
            SRC_TMR0, SRC_TMR1: clr_ok = 1'b1;
            SRC_EXT0:           clr_ok = edge_mode[0];
            SRC_EXT1:           clr_ok = edge_mode[1];
            default:            clr_ok = 1'b0;
        endcase
    end

    // Vector and clear pulse outputs.
    always_comb begin
        vec_addr = '0;
        flag_clr = '0;
        if (take) begin
            vec_addr = VEC_W'(VEC_BASE + VEC_STEP * int'(grant_idx));
            if (clr_ok) flag_clr = SRC_N'(1) << grant_idx;
        end
    end

    // R8: at most one flag is cleared per cycle.
    p_clr_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr));

    // R5: a clear pulse only accompanies an accepted interrupt.
    p_clr_with_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_clr) |-> take && instr_end);
endmodule

// File: tb/tb_irq2_ctrl.sv
// Bench: behavioural reference model compared against the controller every cycle.
module tb_irq2_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [4:0]  irq_set = '0;
    logic        instr_end = 1'b0;
    logic        reti = 1'b0;
    logic        take;
    logic [15:0] vec_addr;
    logic [4:0]  flag_clr;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // Reference model state.
    bit [7:0] m_en;
    bit [4:0] m_pri, m_pnd;
    bit [1:0] m_mode;
    bit       m_hi, m_lo;

    irq2_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_set(irq_set),
        .instr_end(instr_end), .reti(reti), .take(take),
        .vec_addr(vec_addr), .flag_clr(flag_clr)
    );

    always #5 clk = ~clk;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare this cycle's outputs, advance the model, move to the next negedge.
    task automatic tick();
        bit [4:0] act, hreq, lreq, elig, clr;
        bit       e_take, clearable;
        int       win;
        bit [7:0] e_rd;
        #2;
        act  = m_en[7] ? (m_pnd & m_en[4:0]) : 5'd0;
        hreq = act & m_pri;
        lreq = act & ~m_pri;
        if (m_hi)      elig = 0;
        else if (m_lo) elig = hreq;
        else           elig = (hreq != 0) ? hreq : lreq;
        win = -1;
        for (int i = 4; i >= 0; i--) if (elig[i]) win = i;
        e_take = rst_n && instr_end && (win >= 0);
        clr = 0;
        if (e_take) begin
            clearable = (win == 1) || (win == 3) || (win == 0 && m_mode[0]) ||
                        (win == 2 && m_mode[1]);
            if (clearable) clr[win] = 1'b1;
        end
        case (reg_addr)
            2'd0: e_rd = m_en & 8'h9F;
            2'd1: e_rd = {3'b0, m_pri};
            2'd2: e_rd = {3'b0, m_pnd};
            default: e_rd = {2'b0, m_hi, m_lo, 2'b0, m_mode};
        endcase
        chk({cur_req, " take"}, 16'(take), 16'(e_take));
        chk({cur_req, " vector"}, vec_addr, e_take ? 16'(8 * win + 3) : 16'h0000);
        chk({cur_req, " flag_clr"}, 16'(flag_clr), 16'(clr));
        chk({cur_req, " rdata"}, 16'(reg_rdata), 16'(e_rd));
        if (!rst_n) begin
            m_en = 0; m_pri = 0; m_pnd = 0; m_mode = 0; m_hi = 0; m_lo = 0;
        end else begin
            if (reti) begin
                if (m_hi) m_hi = 0; else m_lo = 0;
            end
            if (e_take) begin
                if (m_pri[win]) m_hi = 1; else m_lo = 1;
            end
            if (reg_we) begin
                case (reg_addr)
                    2'd0: m_en = reg_wdata;
                    2'd1: m_pri = reg_wdata[4:0];
                    2'd2: m_pnd = reg_wdata[4:0];
                    default: m_mode = reg_wdata[1:0];
                endcase
            end
            m_pnd = (m_pnd & ~clr) | irq_set;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        reg_we = 0; irq_set = 0; instr_end = 0; reti = 0;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 0;
    endtask

    task automatic boundary();
        instr_end = 1; tick(); instr_end = 0;
    endtask

    task automatic ret();
        reti = 1; tick(); reti = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_en = 0; m_pri = 0; m_pnd = 0; m_mode = 0; m_hi = 0; m_lo = 0;
        @(posedge clk); @(negedge clk);
        // R1: reset state on every register address.
        cur_req = "R1";
        for (int a = 0; a < 4; a++) begin reg_addr = 2'(a); tick(); end
        rst_n = 1;
        for (int a = 0; a < 4; a++) begin reg_addr = 2'(a); tick(); end

        // R2 and R10: pending via software, masked without the global enable.
        cur_req = "R10";
        wr(2'd2, 8'h1F);
        cur_req = "R2";
        wr(2'd0, 8'h7F);
        reg_addr = 2'd0; boundary();
        wr(2'd0, 8'h9E);
        boundary();                 // external 0 masked: timer 0 taken
        ret();
        // R5: no take without a boundary.
        cur_req = "R5";
        wr(2'd0, 8'hFF);
        tick(); tick();
        // R4: polling order, level-mode external 0 not cleared.
        cur_req = "R4";
        reg_addr = 2'd3;
        boundary();
        // R6: equal level blocked while low in service.
        cur_req = "R6";
        boundary();
        cur_req = "R9";
        ret();
        // R10: cancel external 0 by software, then timer 0 wins and is cleared.
        cur_req = "R10";
        wr(2'd2, 8'h1E);
        cur_req = "R8";
        reg_addr = 2'd2;
        boundary(); ret();
        // R3: serial high wins over everything.
        cur_req = "R3";
        wr(2'd1, 8'h10);
        reg_addr = 2'd3;
        boundary();
        cur_req = "R6";
        boundary();                 // nothing preempts a high routine
        ret();
        // R6/R7: low routine entered, high request preempts it.
        cur_req = "R7";
        wr(2'd2, 8'h04);
        wr(2'd3, 8'h02);            // external 1 edge mode
        boundary();                 // low ext1 taken, cleared (R8)
        cur_req = "R6";
        irq_set = 5'h10; tick(); irq_set = 0;
        boundary();                 // serial high preempts
        cur_req = "R9";
        ret();                      // releases high, low stays
        ret();
        // R10: hardware set wins over a same-cycle write clearing it.
        cur_req = "R10";
        reg_addr = 2'd2;
        irq_set = 5'h08; reg_we = 1; reg_wdata = 8'h00; tick(); idle();
        boundary(); ret();
        // R8: edge-mode external 0 cleared on take.
        cur_req = "R8";
        wr(2'd3, 8'h03);
        wr(2'd1, 8'h00);
        irq_set = 5'h01; tick(); irq_set = 0;
        boundary(); ret();

        // R11: random mix of writes, events, boundaries and returns.
        cur_req = "R11";
        wr(2'd0, 8'h9F);
        for (int n = 0; n < 4000; n++) begin
            reg_we    = ($urandom % 8) == 0;
            reg_addr  = 2'($urandom);
            reg_wdata = 8'($urandom);
            if (reg_we && reg_addr == 2'd0 && ($urandom % 2) == 0) reg_wdata[7] = 1'b1;
            irq_set   = (($urandom % 4) == 0) ? 5'($urandom) : 5'd0;
            instr_end = ($urandom % 3) == 0;
            reti      = ($urandom % 6) == 0;
            tick();
        end
        idle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule